// File: doc/BRIEF.md
# MDIO Management Slave

This block is the device-side agent of a two-wire serial management bus. It samples the data line on every rising edge of the management clock. It hunts for a frame of the kind used by 5-bit-addressed transceiver management, and it serves only the frames that carry its own physical address. That address is taken from a 5-bit strap input.

On a write frame, the block collects the 16 data bits and issues a one-cycle write strobe toward an external register file, along with the register address and the data word. On a read frame, the block sends the addressed register back to the station. It leaves the line undriven for the first turnaround bit, drives a zero on the second, and then shifts out the 16 register bits most significant bit first. All slave-driven values change on falling clock edges.

The bidirectional pad is represented by three separate signals: an input, an output and an output-enable. Reset is asynchronous and active low. It is expected to be released synchronously to the management clock before it reaches the block.

Top module: `mdio_slave`

## Requirements
- R1: While reset is asserted and after it is released, `mdio_oe` and `rf_wr` are 0 until a valid frame calls for them.
- R2: A valid frame with opcode 01 (write) produces exactly one `rf_wr` pulse. Its `rf_addr` equals the 5-bit register field, and its `rf_wdata` equals the 16 data bits, where the first data bit received is bit 15. The pulse is visible right after the rising edge that samples the last data bit.
- R3: On a valid frame with opcode 10 (read), the line is not driven during the first turnaround bit. The block drives 0 during the second turnaround bit, then drives the 16 bits of `rf_rdata` for the addressed register, bit 15 first. Every driven value changes on a falling edge of `mdc`.
- R4: The output-enable is released in the bit period right after the last read data bit. It is never held for more than 17 consecutive bit periods.
- R5: A frame whose 5-bit physical address field (sent MSB first, right after the opcode) differs from `phy_addr_strap` causes no `rf_wr` pulse and no drive of the line. A read frame in this case never asserts `mdio_oe`.
- R6: A frame with opcode 00 or 11 causes no `rf_wr` pulse and no drive of the line.
- R7: A frame needs at least 32 consecutive ones before its start pattern 01. With 31 ones the frame is ignored; with exactly 32 it is served.
- R8: A start pattern other than 01 after a valid preamble (for example 00 or 10) causes the frame to be ignored.
- R9: Preambles longer than 32 ones are accepted. A frame that follows the previous one after a single idle bit is served.
- R10: `rf_wr` is high for exactly one `mdc` cycle per write, and is never high while `mdio_oe` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mdc | input | 1 | Management clock; the line is sampled on rising edges |
| rst_n | input | 1 | Asynchronous active-low reset |
| phy_addr_strap | input | 5 | This device's physical address |
| mdio_in | input | 1 | Value seen on the shared data line |
| mdio_out | output | 1 | Value driven when enabled |
| mdio_oe | output | 1 | Drive enable for the shared line |
| rf_addr | output | 5 | Register address of the current frame |
| rf_wdata | output | 16 | Write data toward the register file |
| rf_wr | output | 1 | One-cycle write strobe |
| rf_rdata | input | 16 | Read data for `rf_addr` from the register file |

## Verification
The bench writes and reads back every register address with an arithmetically derived pattern, checking the turnaround timing of each read. A design that drove the first turnaround bit, or that was off by one bit period in its data drive, would show a wrong enable or a shifted word. The bench sends preambles of exactly 31 and 32 ones, which expose a preamble counter with an off-by-one limit. It also sends frames with each single-bit-wrong physical address, with the illegal opcodes and with broken start patterns, and then reads the targeted register back. A slave that skipped the address compare or the opcode check would show a spurious strobe or a corrupted register.

// File: rtl/mdio_pkg.sv
`timescale 1ns/1ps
package mdio_pkg;

  typedef enum logic [2:0] {
    ST_HUNT  = 3'd0,
    ST_START = 3'd1,
    ST_HDR   = 3'd2,
    ST_TA    = 3'd3,
    ST_DATA  = 3'd4
  } mdio_state_e;

  localparam logic [1:0] OP_WR = 2'b01;
  localparam logic [1:0] OP_RD = 2'b10;

endpackage

// File: rtl/mdio_preamble_det.sv
`timescale 1ns/1ps
module mdio_preamble_det #(
  parameter int PRE_LEN = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hunt,
  input  logic bit_in,
  output logic pre_ok
);

  localparam int CW = $clog2(PRE_LEN + 1);
  localparam logic [CW-1:0] PRE_MAX = CW'(PRE_LEN);

  logic [CW-1:0] cnt_q, cnt_d;

  // Saturating run-length of consecutive ones while hunting
  always_comb begin
    cnt_d = cnt_q;
    if (!hunt || !bit_in) begin
      cnt_d = '0;
    end else if (cnt_q != PRE_MAX) begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  assign pre_ok = (cnt_q == PRE_MAX);

endmodule

// File: rtl/mdio_frame_fsm.sv
`timescale 1ns/1ps
module mdio_frame_fsm
  import mdio_pkg::*;
#(
  parameter int PHY_W  = 5,
  parameter int REG_W  = 5,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_in,
  input  logic              pre_ok,
  input  logic [PHY_W-1:0]  phy_strap,
  input  logic [DATA_W-1:0] rd_data,
  output logic              hunt,
  output logic [REG_W-1:0]  reg_addr,
  output logic              wr_stb,
  output logic [DATA_W-1:0] wr_data,
  output logic              tx_en_nxt,
  output logic              tx_bit_nxt
);

  localparam int HDR_W   = 2 + PHY_W + REG_W;
  localparam int CNT_MAX = (HDR_W > DATA_W) ? HDR_W : DATA_W;
  localparam int CNT_W   = $clog2(CNT_MAX);
  localparam logic [CNT_W-1:0] HDR_LAST  = CNT_W'(HDR_W - 1);
  localparam logic [CNT_W-1:0] DATA_LAST = CNT_W'(DATA_W - 1);

  mdio_state_e       st_q, st_d;
  logic [CNT_W-1:0]  bcnt_q, bcnt_d;
  logic [HDR_W-2:0]  hdr_q, hdr_d;
  logic [DATA_W-1:0] sh_q, sh_d;
  logic              is_rd_q, is_rd_d;
  logic [REG_W-1:0]  reg_q, reg_d;
  logic              wr_stb_q, wr_stb_d;
  logic [DATA_W-1:0] wr_data_q, wr_data_d;

  logic [HDR_W-1:0]  hdr_full;
  logic [1:0]        hdr_op;
  logic [PHY_W-1:0]  hdr_phy;
  logic [REG_W-1:0]  hdr_reg;
  logic              hdr_ok;

  assign hdr_full = {hdr_q, bit_in};
  assign hdr_op   = hdr_full[HDR_W-1 -: 2];
  assign hdr_phy  = hdr_full[REG_W +: PHY_W];
  assign hdr_reg  = hdr_full[REG_W-1:0];
  assign hdr_ok   = ((hdr_op == OP_WR) || (hdr_op == OP_RD)) && (hdr_phy == phy_strap);

  always_comb begin
    st_d      = st_q;
    bcnt_d    = bcnt_q;
    hdr_d     = hdr_q;
    sh_d      = sh_q;
    is_rd_d   = is_rd_q;
    reg_d     = reg_q;
    wr_stb_d  = 1'b0;
    wr_data_d = wr_data_q;
    case (st_q)
      ST_HUNT: begin
        if (!bit_in && pre_ok) begin
          st_d = ST_START;
        end
      end
      ST_START: begin
        if (bit_in) begin
          st_d   = ST_HDR;
          bcnt_d = '0;
        end else begin
          st_d = ST_HUNT;
        end
      end
      ST_HDR: begin
        hdr_d = hdr_full[HDR_W-2:0];
        if (bcnt_q == HDR_LAST) begin
          if (hdr_ok) begin
            st_d    = ST_TA;
            bcnt_d  = '0;
            is_rd_d = (hdr_op == OP_RD);
            reg_d   = hdr_reg;
          end else begin
            st_d = ST_HUNT;
          end
        end else begin
          bcnt_d = bcnt_q + 1'b1;
        end
      end
      ST_TA: begin
        if (bcnt_q == '0) begin
          bcnt_d = CNT_W'(1);
          if (is_rd_q) begin
            sh_d = rd_data;
          end
        end else begin
          st_d   = ST_DATA;
          bcnt_d = '0;
        end
      end
      ST_DATA: begin
        sh_d = {sh_q[DATA_W-2:0], bit_in};
        if (bcnt_q == DATA_LAST) begin
          st_d = ST_HUNT;
          if (!is_rd_q) begin
            wr_stb_d  = 1'b1;
            wr_data_d = {sh_q[DATA_W-2:0], bit_in};
          end
        end else begin
          bcnt_d = bcnt_q + 1'b1;
        end
      end
      default: st_d = ST_HUNT;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= ST_HUNT;
      bcnt_q    <= '0;
      hdr_q     <= '0;
      sh_q      <= '0;
      is_rd_q   <= 1'b0;
      reg_q     <= '0;
      wr_stb_q  <= 1'b0;
      wr_data_q <= '0;
    end else begin
      st_q      <= st_d;
      bcnt_q    <= bcnt_d;
      hdr_q     <= hdr_d;
      sh_q      <= sh_d;
      is_rd_q   <= is_rd_d;
      reg_q     <= reg_d;
      wr_stb_q  <= wr_stb_d;
      wr_data_q <= wr_data_d;
    end
  end

  assign hunt       = (st_q == ST_HUNT);
  assign reg_addr   = reg_q;
  assign wr_stb     = wr_stb_q;
  assign wr_data    = wr_data_q;
  // Second turnaround bit and every data bit of a read are driven
  assign tx_en_nxt  = is_rd_q && (((st_q == ST_TA) && (bcnt_q != '0)) || (st_q == ST_DATA));
  assign tx_bit_nxt = (st_q == ST_DATA) ? sh_q[DATA_W-1] : 1'b0;

endmodule

// File: rtl/mdio_tx_drv.sv
`timescale 1ns/1ps
module mdio_tx_drv (
  input  logic clk,
  input  logic rst_n,
  input  logic tx_en,
  input  logic tx_bit,
  output logic line_oe,
  output logic line_out
);

  logic oe_d, out_d;

  always_comb begin
    oe_d  = tx_en;
    out_d = tx_en ? tx_bit : 1'b0;
  end

  // Launch on the falling edge; the station samples on the rising edge
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_oe  <= 1'b0;
      line_out <= 1'b0;
    end else begin
      line_oe  <= oe_d;
      line_out <= out_d;
    end
  end

endmodule

// File: rtl/mdio_slave.sv
`timescale 1ns/1ps
module mdio_slave #(
  parameter int PHY_W   = 5,
  parameter int REG_W   = 5,
  parameter int DATA_W  = 16,
  parameter int PRE_LEN = 32
) (
  input  logic              mdc,
  input  logic              rst_n,
  input  logic [PHY_W-1:0]  phy_addr_strap,
  input  logic              mdio_in,
  output logic              mdio_out,
  output logic              mdio_oe,
  output logic [REG_W-1:0]  rf_addr,
  output logic [DATA_W-1:0] rf_wdata,
  output logic              rf_wr,
  input  logic [DATA_W-1:0] rf_rdata
);

  logic hunt;
  logic pre_ok;
  logic tx_en_nxt;
  logic tx_bit_nxt;

  mdio_preamble_det #(.PRE_LEN(PRE_LEN)) u_pre (
    .clk    (mdc),
    .rst_n  (rst_n),
    .hunt   (hunt),
    .bit_in (mdio_in),
    .pre_ok (pre_ok)
  );

  mdio_frame_fsm #(.PHY_W(PHY_W), .REG_W(REG_W), .DATA_W(DATA_W)) u_fsm (
    .clk        (mdc),
    .rst_n      (rst_n),
    .bit_in     (mdio_in),
    .pre_ok     (pre_ok),
    .phy_strap  (phy_addr_strap),
    .rd_data    (rf_rdata),
    .hunt       (hunt),
    .reg_addr   (rf_addr),
    .wr_stb     (rf_wr),
    .wr_data    (rf_wdata),
    .tx_en_nxt  (tx_en_nxt),
    .tx_bit_nxt (tx_bit_nxt)
  );

  mdio_tx_drv u_tx (
    .clk      (mdc),
    .rst_n    (rst_n),
    .tx_en    (tx_en_nxt),
    .tx_bit   (tx_bit_nxt),
    .line_oe  (mdio_oe),
    .line_out (mdio_out)
  );

endmodule

// File: rtl/mdio_slave_chk.sv
`timescale 1ns/1ps
module mdio_slave_chk #(
  parameter int DATA_W = 16
) (
  input logic mdc,
  input logic rst_n,
  input logic mdio_oe,
  input logic mdio_out,
  input logic rf_wr
);

  localparam int RUN_MAX = DATA_W + 1;
  localparam int RW      = $clog2(RUN_MAX + 2) + 1;
  localparam logic [RW-1:0] RUN_SAT = RW'(RUN_MAX + 1);

  logic [RW-1:0] oe_run_q;

  always_ff @(posedge mdc or negedge rst_n) begin
    if (!rst_n) begin
      oe_run_q <= '0;
    end else if (!mdio_oe) begin
      oe_run_q <= '0;
    end else if (oe_run_q != RUN_SAT) begin
      oe_run_q <= oe_run_q + 1'b1;
    end
  end

  // R10: strobe lasts one cycle
  a_r10_wr_single: assert property (@(posedge mdc) disable iff (!rst_n)
    rf_wr |=> !rf_wr);

  // R10: write strobe and drive never overlap
  a_r10_wr_excl_oe: assert property (@(posedge mdc) disable iff (!rst_n)
    rf_wr |-> !mdio_oe);

  // R3: first driven bit is the zero of the turnaround
  a_r3_ta_zero: assert property (@(posedge mdc) disable iff (!rst_n)
    $rose(mdio_oe) |-> !mdio_out);

  // R4: drive window is bounded
  a_r4_oe_bounded: assert property (@(posedge mdc) disable iff (!rst_n)
    oe_run_q <= RW'(RUN_MAX));

endmodule

bind mdio_slave mdio_slave_chk #(.DATA_W(DATA_W)) u_chk (
  .mdc      (mdc),
  .rst_n    (rst_n),
  .mdio_oe  (mdio_oe),
  .mdio_out (mdio_out),
  .rf_wr    (rf_wr)
);

// File: tb/test_mdio_slave.sv
`timescale 1ns/1ps
module test_mdio_slave;

  localparam logic [4:0] MY_PHY = 5'h13;
  localparam logic [1:0] WR = 2'b01;
  localparam logic [1:0] RD = 2'b10;

  logic        mdc = 1'b0;
  logic        rst_n;
  logic        drv;
  logic        mdio_in;
  logic        mdio_out;
  logic        mdio_oe;
  logic [4:0]  rf_addr;
  logic [15:0] rf_wdata;
  logic        rf_wr;
  logic [15:0] rf_rdata;
  logic [15:0] mem [32];

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  logic s_oe, s_out, s_wr;
  int   f_wr_cnt, f_oe_cnt, f_rd_oe_n;
  logic [4:0]  f_wr_addr;
  logic [15:0] f_wr_data, f_rd_word;
  logic f_ta1_oe, f_ta2_oe, f_ta2_out, f_wr_last, f_idle_oe, f_idle_wr;

  always #10 mdc = ~mdc;

  assign mdio_in  = mdio_oe ? mdio_out : drv;
  assign rf_rdata = mem[rf_addr];

  always @(posedge mdc) if (rf_wr) mem[rf_addr] <= rf_wdata;

  mdio_slave i_mdio_slave (
    .mdc            (mdc),
    .rst_n          (rst_n),
    .phy_addr_strap (MY_PHY),
    .mdio_in        (mdio_in),
    .mdio_out       (mdio_out),
    .mdio_oe        (mdio_oe),
    .rf_addr        (rf_addr),
    .rf_wdata       (rf_wdata),
    .rf_wr          (rf_wr),
    .rf_rdata       (rf_rdata)
  );

  function automatic logic [15:0] pat(input logic [4:0] r, input logic [15:0] salt);
    return (16'h3C5A ^ salt) ^ (16'(r) * 16'h0B17);
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bitx(input logic b);
    @(negedge mdc);
    drv = b;
    @(posedge mdc);
    #5;
    s_oe  = mdio_oe;
    s_out = mdio_out;
    s_wr  = rf_wr;
    if (s_oe) f_oe_cnt++;
    if (s_wr) begin
      f_wr_cnt++;
      f_wr_addr = rf_addr;
      f_wr_data = rf_wdata;
    end
  endtask

  task automatic frame(input int npre, input logic [1:0] st, input logic [1:0] op,
                       input logic [4:0] phy, input logic [4:0] rg, input logic [15:0] wd);
    f_wr_cnt = 0; f_oe_cnt = 0; f_rd_oe_n = 0;
    f_wr_last = 1'b0; f_rd_word = '0;
    for (int i = 0; i < npre; i++) bitx(1'b1);
    bitx(st[1]); bitx(st[0]);
    bitx(op[1]); bitx(op[0]);
    for (int i = 4; i >= 0; i--) bitx(phy[i]);
    for (int i = 4; i >= 0; i--) bitx(rg[i]);
    bitx(1'b1);
    f_ta1_oe = s_oe;
    bitx((op == RD) ? 1'b1 : 1'b0);
    f_ta2_oe = s_oe; f_ta2_out = s_out;
    for (int i = 15; i >= 0; i--) begin
      bitx((op == RD) ? 1'b1 : wd[i]);
      f_rd_word[i] = s_out;
      if (s_oe) f_rd_oe_n++;
      if (i == 0) f_wr_last = s_wr;
    end
    bitx(1'b1);
    f_idle_oe = s_oe; f_idle_wr = s_wr;
  endtask

  task automatic do_write(input string tag, input int npre, input logic [4:0] rg, input logic [15:0] wd);
    frame(npre, 2'b01, WR, MY_PHY, rg, wd);
    chk({tag, " write strobe count"}, f_wr_cnt, 1);
    chk({tag, " write address"}, f_wr_addr, rg);
    chk({tag, " write data"}, f_wr_data, wd);
    chk({tag, " strobe after last bit"}, f_wr_last, 1);
    chk({"R10 strobe one cycle"}, f_idle_wr, 0);
    chk({tag, " no drive on write"}, f_oe_cnt, 0);
  endtask

  task automatic do_read(input string tag, input int npre, input logic [4:0] rg, input logic [15:0] exp);
    frame(npre, 2'b01, RD, MY_PHY, rg, 16'h0);
    chk({tag, " TA1 undriven"}, f_ta1_oe, 0);
    chk({tag, " TA2 driven"}, f_ta2_oe, 1);
    chk({tag, " TA2 zero"}, f_ta2_out, 0);
    chk({tag, " data driven 16 bits"}, f_rd_oe_n, 16);
    chk({tag, " read data"}, f_rd_word, exp);
    chk({"R4 released after data"}, f_idle_oe, 0);
    chk({tag, " no strobe on read"}, f_wr_cnt, 0);
  endtask

  task automatic expect_ignored(input string tag);
    chk({tag, " no strobe"}, f_wr_cnt, 0);
    chk({tag, " no drive"}, f_oe_cnt, 0);
  endtask

  initial begin
    repeat (150000) @(posedge mdc);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 32; i++) mem[i] = 16'h0;
    drv   = 1'b1;
    rst_n = 1'b0;
    repeat (3) @(posedge mdc);
    #5;
    chk("R1 oe in reset", mdio_oe, 0);
    chk("R1 wr in reset", rf_wr, 0);
    @(negedge mdc);
    rst_n = 1'b1;
    repeat (4) @(posedge mdc);
    #5;
    chk("R1 oe after reset", mdio_oe, 0);
    chk("R1 wr after reset", rf_wr, 0);

    // R2 / R3: full sweep of register addresses
    for (int r = 0; r < 32; r++) do_write("R2", 32, 5'(r), pat(5'(r), 16'h0));
    for (int r = 0; r < 32; r++) do_read("R3", 32, 5'(r), pat(5'(r), 16'h0));

    // R5: every single-bit-wrong physical address
    for (int b = 0; b < 5; b++) begin
      frame(32, 2'b01, WR, MY_PHY ^ (5'd1 << b), 5'd7, 16'hDEAD);
      expect_ignored("R5 write other phy");
      frame(32, 2'b01, RD, MY_PHY ^ (5'd1 << b), 5'd7, 16'h0);
      expect_ignored("R5 read other phy");
    end
    do_read("R5 reg untouched", 32, 5'd7, pat(5'd7, 16'h0));

    // R6: illegal opcodes
    frame(32, 2'b01, 2'b00, MY_PHY, 5'd9, 16'hBEEF);
    expect_ignored("R6 opcode 00");
    frame(32, 2'b01, 2'b11, MY_PHY, 5'd9, 16'hBEEF);
    expect_ignored("R6 opcode 11");
    do_read("R6 reg untouched", 32, 5'd9, pat(5'd9, 16'h0));

    // R7: 31 ones ignored, exactly 32 accepted
    bitx(1'b0);
    frame(31, 2'b01, WR, MY_PHY, 5'd3, 16'h1234);
    expect_ignored("R7 short preamble");
    do_read("R7 reg untouched", 32, 5'd3, pat(5'd3, 16'h0));
    bitx(1'b0);
    do_write("R7 exact preamble", 32, 5'd3, 16'h1234);
    do_read("R7 readback", 32, 5'd3, 16'h1234);

    // R8: broken start patterns
    frame(32, 2'b00, WR, MY_PHY, 5'd12, 16'hCAFE);
    expect_ignored("R8 start 00");
    frame(32, 2'b10, WR, MY_PHY, 5'd12, 16'hCAFE);
    expect_ignored("R8 start 10");
    do_read("R8 reg untouched", 32, 5'd12, pat(5'd12, 16'h0));

    // R9: long preambles, back-to-back frames
    for (int r = 20; r < 24; r++) do_write("R9", 40 + r, 5'(r), pat(5'(r), 16'h5A5A));
    for (int r = 20; r < 24; r++) do_read("R9", 33, 5'(r), pat(5'(r), 16'h5A5A));

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

endmodule